// File: doc/BRIEF.md
# Serial Register Expander Slave

This block is the serial-peripheral slave front end of a small register expander. A host drives the serial clock, an active-low select and the host-to-slave data line. Every exchange is exactly sixteen clock pulses long. The first byte is a command that holds a register address and a direction flag. The second byte holds the value to store when the command is a write. The block oversamples the three serial inputs with a system clock through a short synchronizer. It decodes each complete exchange and reaches the register bank through a simple parallel port: a write strobe with address and data, and a read strobe with address and returned data. The register contents live outside the block. Address zero is the exception: it answers with a fixed revision constant held in the block.

Read data is pipelined across exchanges. On the slave-to-host line the first byte is always zero. The second byte is the content of a holding register, and only a read command loads that register, at the end of its own exchange. The value a read asks for therefore comes back during the next exchange. A write exchange, including an all-zero dummy exchange, leaves the held value alone, so the host can fetch the result of its last read with a dummy exchange.

The control is a five-state machine:
- `ST_IDLE` waits for the select to go low (transition *select*).
- `ST_CMD` shifts in the command byte; *cmd_done* after the eighth rising edge leads to `ST_PAYLOAD`.
- `ST_PAYLOAD` shifts in the second byte; *payload_done* after the sixteenth rising edge leads to `ST_COMMIT`.
- `ST_COMMIT` lasts one cycle and issues the strobes, then goes to `ST_TAIL` (*hold_select*) or straight to `ST_IDLE` (*release*).
- `ST_TAIL` ignores further clock pulses until the select rises (*release*).
- A rising select in `ST_CMD` or `ST_PAYLOAD` is the *abort* transition back to `ST_IDLE`.

Top module: `spi_reg_expander`

## Requirements
- R1: An exchange is 16 rising serial-clock edges under a low select, most significant bit first. The command byte (first 8 bits) carries the address in bits 7:1 and the direction in bit 0, where 1 means read and 0 means write. The following 8 bits are the payload.
- R2: The first 8 bits driven on `spi_miso` in every exchange are zero.
- R3: Bits 9 to 16 on `spi_miso` carry the holding register, most significant bit first. Each bit changes only after a falling serial-clock edge and is stable at the next rising edge. The holding register is zero after reset.
- R4: A complete read exchange loads the holding register at its end with the addressed value, so that value is returned in the second byte of the next exchange.
- R5: A complete write exchange, including the all-zero dummy command, leaves the holding register unchanged.
- R6: A complete write to an address from 1 to NREGS-1 gives exactly one single-cycle `reg_wr_en` pulse, with `reg_addr` equal to the address and `reg_wr_data` equal to the payload.
- R7: A write to address 0 or to any address at or above NREGS produces no `reg_wr_en` pulse.
- R8: A read of address 0 returns the REVISION parameter and a read of an address at or above NREGS returns zero; neither pulses `reg_rd_en`.
- R9: A read of an address from 1 to NREGS-1 gives exactly one single-cycle `reg_rd_en` pulse, and `reg_rd_data` is sampled in that same cycle.
- R10: Raising the select before the 16th rising edge discards the exchange: no strobe, no change to the holding register, and the next exchange starts again from bit 1.
- R11: `spi_miso` is low while the select is high.
- R12: After reset both strobes are low, and `reg_wr_en` and `reg_rd_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data |
| reg_addr | output | $clog2(NREGS) | Register address for either strobe |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | DATA_W | Value to store |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rd_data | input | DATA_W | Register value, sampled while `reg_rd_en` is high |

## Verification
The assertions assume that the serial lines are slow compared with `clk`. Each serial-clock half period must last several system cycles, so that every edge is seen after synchronization and the commit cycle finishes before the select rises. They also assume that `reg_rd_data` answers `reg_addr` combinationally. The stimulus keeps these conditions. It holds each half period at eight system cycles and changes the data and select lines only while the serial clock is low. It also leaves several half periods of idle select between exchanges. Random commands mix valid, zero and out-of-range addresses with both directions, and directed cases add dummy exchanges and selects that rise partway through an exchange.

// File: rtl/spi_regx_pkg.sv
package spi_regx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_PAYLOAD,
        ST_COMMIT,
        ST_TAIL
    } xp_state_e;

    localparam int SYNC_LINES = 3;
    localparam int LINE_SCK   = 0;
    localparam int LINE_CSN   = 1;
    localparam int LINE_MOSI  = 2;

endpackage

// File: rtl/spi_regx_sync.sv
module spi_regx_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_line
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], din[b]};
            end
        end

        assign dout[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_regx_rx.sv
module spi_regx_rx #(
    parameter int TOTAL_BITS = 16,
    parameter int CNT_W      = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  sample,
    input  logic                  din,
    output logic [TOTAL_BITS-1:0] frame,
    output logic [CNT_W-1:0]      count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame <= '0;
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (sample) begin
            frame <= {frame[TOTAL_BITS-2:0], din};
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/spi_regx_tx.sv
module spi_regx_tx #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_fall,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic [CNT_W-1:0]  count,
    output logic              miso
);

    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] snap;
    logic [CNT_W-1:0]  idx;
    logic              in_second;

    assign in_second = (count >= CNT_W'(DATA_W)) && (count < CNT_W'(2 * DATA_W));
    assign idx       = CNT_W'(2 * DATA_W - 1) - count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap <= '0;
            miso <= 1'b0;
        end else begin
            if (load) begin
                snap <= load_val;
            end
            if (cs_n_s) begin
                miso <= 1'b0;
            end else if (sck_fall) begin
                miso <= in_second ? snap[idx[IDX_W-1:0]] : 1'b0;
            end
        end
    end

endmodule

// File: rtl/spi_regx_ctrl.sv
module spi_regx_ctrl
    import spi_regx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREGS  = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_rise,
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-2:0] cmd_addr,
    input  logic              cmd_read,
    output logic              sample,
    output logic              rx_clr,
    output logic              tx_load,
    output logic              wr_en,
    output logic              rd_en,
    output logic              hold_load
);

    xp_state_e state_q, state_d;
    logic      in_range;
    logic      is_rev;
    logic      shifting;

    assign in_range = cmd_addr < (DATA_W - 1)'(NREGS);
    assign is_rev   = cmd_addr == '0;
    assign shifting = (state_q == ST_CMD) || (state_q == ST_PAYLOAD);
    assign sample   = sck_rise && shifting && !cs_n_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_n_s) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (cs_n_s) state_d = ST_IDLE;
                else if (sample && count == CNT_W'(DATA_W - 1)) state_d = ST_PAYLOAD;
            end
            ST_PAYLOAD: begin
                if (cs_n_s) state_d = ST_IDLE;
                else if (sample && count == CNT_W'(2 * DATA_W - 1)) state_d = ST_COMMIT;
            end
            ST_COMMIT: begin
                state_d = cs_n_s ? ST_IDLE : ST_TAIL;
            end
            ST_TAIL: begin
                if (cs_n_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rx_clr    = (state_q == ST_IDLE);
        tx_load   = 1'b0;
        wr_en     = 1'b0;
        rd_en     = 1'b0;
        hold_load = 1'b0;
        unique case (state_q)
            ST_CMD: begin
                tx_load = sample && (count == CNT_W'(DATA_W - 1));
            end
            ST_COMMIT: begin
                wr_en     = !cmd_read && in_range && !is_rev;
                rd_en     = cmd_read && in_range && !is_rev;
                hold_load = cmd_read;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spi_reg_expander.sv
module spi_reg_expander
    import spi_regx_pkg::*;
#(
    parameter int               NREGS       = 16,
    parameter int               DATA_W      = 8,
    parameter int               SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] REVISION   = 8'h5A
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sck,
    input  logic                       spi_cs_n,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    output logic [$clog2(NREGS)-1:0]   reg_addr,
    output logic                       reg_wr_en,
    output logic [DATA_W-1:0]          reg_wr_data,
    output logic                       reg_rd_en,
    input  logic [DATA_W-1:0]          reg_rd_data
);

    localparam int ADDR_W     = $clog2(NREGS);
    localparam int TOTAL_BITS = 2 * DATA_W;
    localparam int CNT_W      = $clog2(TOTAL_BITS + 1);
    localparam logic [SYNC_LINES-1:0] SYNC_RST = SYNC_LINES'(1) << LINE_CSN;

    logic [SYNC_LINES-1:0] raw_lines, sync_lines;
    logic                  sck_s, cs_n_s, mosi_s, sck_d;
    logic                  sck_rise, sck_fall;
    logic [TOTAL_BITS-1:0] frame;
    logic [CNT_W-1:0]      count;
    logic [DATA_W-2:0]     cmd_addr;
    logic                  cmd_read;
    logic                  sample, rx_clr, tx_load, hold_load;
    logic [DATA_W-1:0]     hold_q;
    logic [DATA_W-1:0]     read_val;

    assign raw_lines[LINE_SCK]  = spi_sck;
    assign raw_lines[LINE_CSN]  = spi_cs_n;
    assign raw_lines[LINE_MOSI] = spi_mosi;

    spi_regx_sync #(
        .WIDTH   (SYNC_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    assign sck_s  = sync_lines[LINE_SCK];
    assign cs_n_s = sync_lines[LINE_CSN];
    assign mosi_s = sync_lines[LINE_MOSI];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign sck_rise = sck_s && !sck_d;
    assign sck_fall = !sck_s && sck_d;

    spi_regx_rx #(
        .TOTAL_BITS(TOTAL_BITS),
        .CNT_W     (CNT_W)
    ) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .sample(sample),
        .din   (mosi_s),
        .frame (frame),
        .count (count)
    );

    assign cmd_addr = frame[TOTAL_BITS-1:DATA_W+1];
    assign cmd_read = frame[DATA_W];

    spi_regx_ctrl #(
        .DATA_W(DATA_W),
        .NREGS (NREGS),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (cs_n_s),
        .sck_rise (sck_rise),
        .count    (count),
        .cmd_addr (cmd_addr),
        .cmd_read (cmd_read),
        .sample   (sample),
        .rx_clr   (rx_clr),
        .tx_load  (tx_load),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .hold_load(hold_load)
    );

    assign reg_addr    = frame[DATA_W+ADDR_W:DATA_W+1];
    assign reg_wr_data = frame[DATA_W-1:0];

    always_comb begin
        if (cmd_addr == '0)                          read_val = REVISION;
        else if (cmd_addr < (DATA_W - 1)'(NREGS))    read_val = reg_rd_data;
        else                                         read_val = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hold_q <= '0;
        else if (hold_load) hold_q <= read_val;
    end

    spi_regx_tx #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (cs_n_s),
        .sck_fall(sck_fall),
        .load    (tx_load),
        .load_val(hold_q),
        .count   (count),
        .miso    (spi_miso)
    );

endmodule

// File: rtl/spi_regx_chk.sv
module spi_regx_chk #(
    parameter int NREGS  = 16,
    parameter int DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_n_s,
    input logic                     sck_fall,
    input logic                     miso,
    input logic                     reg_wr_en,
    input logic                     reg_rd_en,
    input logic [$clog2(NREGS)-1:0] reg_addr,
    input logic [DATA_W-1:0]        hold_q,
    input logic                     hold_load
);

    a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    a_r7_no_write_to_rev: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> reg_addr != '0);

    a_r6_write_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    a_r9_read_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);

    a_r11_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> !miso);

    a_r3_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !sck_fall) |=> $stable(miso));

    a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_load |=> $stable(hold_q));

endmodule

bind spi_reg_expander spi_regx_chk #(
    .NREGS (NREGS),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_s   (cs_n_s),
    .sck_fall (sck_fall),
    .miso     (spi_miso),
    .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en),
    .reg_addr (reg_addr),
    .hold_q   (hold_q),
    .hold_load(hold_load)
);

// File: tb/test_spi_reg_expander.sv
`timescale 1ns/1ps
module test_spi_reg_expander;

    localparam int          NREGS = 16;
    localparam logic [7:0]  REV   = 8'h5A;
    localparam int          HALF  = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic [3:0] reg_addr;
    logic       reg_wr_en, reg_rd_en;
    logic [7:0] reg_wr_data, reg_rd_data;

    logic [7:0] rf    [NREGS];
    logic [7:0] model [NREGS];
    logic [7:0] m_hold;
    int         wr_cnt = 0, rd_cnt = 0;
    logic [3:0] last_wa;
    logic [7:0] last_wd;
    int         checks = 0, errors = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    spi_reg_expander #(.NREGS(NREGS), .DATA_W(8), .SYNC_STAGES(2), .REVISION(REV)) i_spi_reg_expander (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data)
    );

    assign reg_rd_data = rf[reg_addr];

    always @(posedge clk) begin
        if (reg_wr_en) begin
            wr_cnt++;
            last_wa = reg_addr;
            last_wd = reg_wr_data;
            rf[reg_addr] <= reg_wr_data;
        end
        if (reg_rd_en) rd_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [6:0] a);
        if (a == 0)          return REV;
        else if (a < NREGS)  return model[a[3:0]];
        else                 return 8'h00;
    endfunction

    task automatic xfer(input logic [15:0] word, input int nbits,
                        output logic [7:0] b1, output logic [7:0] b2);
        logic [15:0] got = '0;
        spi_cs_n = 1'b0;
        #HALF;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = word[15-i];
            #HALF;
            spi_sck = 1'b1;
            got[15-i] = spi_miso;
            #HALF;
            spi_sck = 1'b0;
        end
        #HALF;
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        #(4*HALF);
        b1 = got[15:8];
        b2 = got[7:0];
    endtask

    task automatic do_txn(input logic [6:0] a, input logic rw, input logic [7:0] d);
        logic [7:0] b1, b2;
        int  w0 = wr_cnt, r0 = rd_cnt;
        bit  valid = (a != 0) && (a < NREGS);
        xfer({a, rw, d}, 16, b1, b2);
        chk(b1 == 8'h00, "R2 first byte", b1, 0);
        chk(b2 == m_hold, "R3 R4 R5 second byte", b2, m_hold);
        chk(spi_miso == 1'b0, "R11 idle line", spi_miso, 0);
        if (!rw) begin
            chk(wr_cnt - w0 == (valid ? 1 : 0), valid ? "R6 write pulse" : "R7 ignored write",
                wr_cnt - w0, valid ? 1 : 0);
            if (valid) begin
                chk(last_wa == a[3:0] && last_wd == d, "R1 R6 address and data",
                    {last_wa, last_wd}, {a[3:0], d});
                model[a[3:0]] = d;
            end
            chk(rd_cnt == r0, "R12 no read on write", rd_cnt - r0, 0);
        end else begin
            chk(rd_cnt - r0 == (valid ? 1 : 0), valid ? "R9 read pulse" : "R8 no read pulse",
                rd_cnt - r0, valid ? 1 : 0);
            chk(wr_cnt == w0, "R12 no write on read", wr_cnt - w0, 0);
            m_hold = exp_read(a);
        end
    endtask

    task automatic abort_txn(input logic [15:0] word, input int nbits);
        logic [7:0] b1, b2;
        int w0 = wr_cnt, r0 = rd_cnt;
        xfer(word, nbits, b1, b2);
        chk(wr_cnt == w0 && rd_cnt == r0, "R10 abort strobes",
            (wr_cnt - w0) + (rd_cnt - r0), 0);
        chk(spi_miso == 1'b0, "R11 after abort", spi_miso, 0);
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) begin
            rf[i] = 8'h00;
            model[i] = 8'h00;
        end
        m_hold = 8'h00;
        #40;
        rst_n = 1'b1;
        #40;
        chk(spi_miso == 0 && reg_wr_en == 0 && reg_rd_en == 0, "R12 reset outputs",
            {spi_miso, reg_wr_en, reg_rd_en}, 0);

        do_txn(7'd0, 1'b1, 8'h00);            // R8 revision read, R3 reset hold
        do_txn(7'd0, 1'b0, 8'h00);            // R4 dummy returns revision
        do_txn(7'd0, 1'b0, 8'h00);            // R5 held again
        do_txn(7'd0, 1'b0, 8'hFF);            // R7 write to revision
        do_txn(7'd0, 1'b1, 8'h00);
        do_txn(7'd3, 1'b0, 8'hA5);            // R6
        do_txn(7'd3, 1'b1, 8'h00);
        do_txn(7'd0, 1'b0, 8'h00);            // R4 returns A5
        do_txn(7'd100, 1'b0, 8'h77);          // R7 out of range
        do_txn(7'd100, 1'b1, 8'h00);          // R8 out of range read
        do_txn(7'd15, 1'b0, 8'h3C);
        do_txn(7'd0, 1'b0, 8'h00);

        abort_txn({7'd3, 1'b0, 8'h11}, 12);   // R10 abort in payload
        abort_txn({7'd3, 1'b1, 8'h00}, 5);    // R10 abort in command
        do_txn(7'd3, 1'b1, 8'h00);
        do_txn(7'd15, 1'b1, 8'h00);
        do_txn(7'd0, 1'b0, 8'h00);

        void'($urandom(32'hC0DE));
        for (int n = 0; n < 110; n++) begin
            int unsigned r = $urandom % 24;
            logic [6:0] a = (r < 16) ? 7'(r) : 7'(16 + ($urandom % 112));
            do_txn(a, 1'($urandom % 2), 8'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule